// File: doc/BRIEF.md
# Configurable Frame Serial Receiver

This block turns an asynchronous serial line into characters. It uses the same frame settings as its companion transmitter: a 3-bit character-size code, a 2-bit parity code and a 12-bit rate divisor. It oversamples the line sixteen times per bit. A falling edge starts a frame, and the start bit is confirmed at mid-bit. Each later bit is resolved by a majority vote over the three middle samples. Characters of up to nine bits go into a one-entry holding buffer, which host logic empties with a read strobe.

Three flags travel with each held character: a framing flag, a parity flag and an overrun flag. A receive-complete level shows that unread data is held. An interrupt request follows that level when the interrupt enable is set. Clearing the enable input flushes the buffer and all three flags and returns the decoder to idle.

The stop-bit count setting belongs to the transmitter. The receiver takes the input and ignores it, and checks only the first stop bit. If the divisor changes in the middle of a frame, that frame is corrupted; the block does not protect against this.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_done`, `irq`, `frame_err`, `parity_err` and `overrun` are all low.
- R2: A frame is one low start bit, then the data bits least significant first, then an optional parity bit, then a high stop bit. `size_sel` 000, 001, 010, 011 and 111 select 5, 6, 7, 8 and 9 data bits. The reserved codes 100, 101 and 110 act as 8 bits. Data bits beyond the selected size read as zero.
- R3: In 9-bit mode the ninth received bit appears on `data_hi` and the low eight bits appear on `data_low`.
- R4: `parity_sel` 10 expects even parity over the data bits and 11 expects odd parity. Codes 00 and 01 mean no parity bit. When parity is on and the received parity bit mismatches, `parity_err` is set for that character.
- R5: A first stop bit sampled low sets `frame_err` for that character. The data bits are still delivered.
- R6: `stop_sel` has no effect. With it set, a frame carrying a single stop bit is received without error, and a start bit that follows at once is accepted.
- R7: If a character completes while `rx_done` is high and no read is made in that cycle, the new character is dropped. The held data is kept and `overrun` is set.
- R8: `rx_done` is high exactly while unread data is held. `irq` is high when `rx_done` and `irq_en` are both high.
- R9: A one-cycle `rd_low` pulse while data is held clears `rx_done` and the three flags.
- R10: Driving `rx_en` low clears `rx_done`, `frame_err`, `parity_err` and `overrun` on the next clock edge, and discards any frame in progress.
- R11: A low pulse on the idle line that is shorter than half a bit does not produce a character.
- R12: With divisor value d, one bit lasts 16*(d+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer and flags |
| size_sel | input | 3 | Character size code |
| parity_sel | input | 2 | Parity mode code |
| stop_sel | input | 1 | Stop-bit count setting (ignored by the receiver) |
| divisor | input | 12 | Rate divisor; one oversample tick every divisor+1 clocks |
| irq_en | input | 1 | Receive-complete interrupt enable |
| rxd | input | 1 | Serial line, idle high |
| rd_low | input | 1 | Read strobe that pops the held character |
| data_low | output | 8 | Low eight bits of the held character |
| data_hi | output | 1 | Ninth bit of the held character |
| frame_err | output | 1 | The held character's stop bit was low |
| parity_err | output | 1 | The held character failed its parity check |
| overrun | output | 1 | A newer character was dropped |
| rx_done | output | 1 | Unread character present |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench sends a 6-bit character with the top bits set high on the line. A design that ignored the size code would shift those stop-bit ones into `data_low`.

It feeds a bad parity bit under both parity senses. A design with the odd and even senses swapped would flag correct frames and pass bad ones.

It sends two frames without a read in between. A buffer that overwrote its content would show the second character instead of raising `overrun` over the first.

It also checks three more cases:
- a short low glitch on the idle line, which a decoder with no mid-bit confirmation would turn into a spurious character;
- a frame with a bad parity bit followed by a disable, where a design that left its flags set would still report the parity error;
- a second frame sent straight after a single stop bit with the two-stop setting on, where a design that honoured that setting would miss the second start bit.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   localparam int CHAR_W = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_t;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              fe;
      logic              pe;
   } rx_char_t;

   // size code to number of data bits; reserved codes act as 8
   function automatic logic [3:0] char_bits(input logic [2:0] code);
      case (code)
         3'b000:  char_bits = 4'd5;
         3'b001:  char_bits = 4'd6;
         3'b010:  char_bits = 4'd7;
         3'b111:  char_bits = 4'd9;
         default: char_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = en && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!en)      cnt_q <= '0;
      else if (cnt_q == '0) cnt_q <= divisor;
      else               cnt_q <= cnt_q - 1'b1;
   end

   // two ticks in a row only when the divisor is zero
   p_tick_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor != '0) |=> !tick);

endmodule

// File: rtl/sfr_sync.sv
module sfr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else if (STAGES == 1) q <= din;
            else q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
   import sfr_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       line,
   input  logic [2:0] size_sel,
   input  logic [1:0] parity_sel,
   output logic       done,
   output rx_char_t   rx_char
);

   localparam int PW   = $clog2(OVS);
   localparam int MID  = OVS / 2;
   localparam logic [PW-1:0] PH_V0   = PW'(MID - 1);
   localparam logic [PW-1:0] PH_V1   = PW'(MID);
   localparam logic [PW-1:0] PH_DEC  = PW'(MID + 1);
   localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

   rx_state_t         st_q;
   logic [PW-1:0]     phase_q;
   logic [1:0]        votes_q;
   logic              prev_q;
   logic [3:0]        idx_q;
   logic [CHAR_W-1:0] sh_q;
   logic              par_q, fe_q, pe_q;

   logic       vbit;
   logic       par_on;
   logic [3:0] nbits;

   assign vbit   = (votes_q + {1'b0, line}) >= 2'd2;
   assign par_on = parity_sel[1];
   assign nbits  = char_bits(size_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; phase_q <= '0; votes_q <= '0; prev_q <= 1'b1;
         idx_q <= '0; sh_q <= '0; par_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
         done <= 1'b0;
      end else if (!en) begin
         st_q <= ST_IDLE; phase_q <= '0; votes_q <= '0; prev_q <= 1'b1;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (st_q == ST_IDLE) begin
               prev_q <= line;
               if (prev_q && !line) begin
                  st_q    <= ST_START;
                  phase_q <= PW'(1);
                  votes_q <= '0;
                  sh_q    <= '0;
               end
            end else begin
               phase_q <= phase_q + 1'b1;
               if (phase_q == PH_V0 || phase_q == PH_V1)
                  votes_q <= votes_q + {1'b0, line};
               if (phase_q == PH_DEC) begin
                  case (st_q)
                     ST_START: if (vbit) st_q <= ST_IDLE;
                     ST_DATA:  sh_q[idx_q] <= vbit;
                     ST_PAR:   par_q <= vbit;
                     ST_STOP: begin
                        done   <= 1'b1;
                        fe_q   <= !vbit;
                        pe_q   <= par_on && (par_q != ((^sh_q) ^ parity_sel[0]));
                        st_q   <= ST_IDLE;
                        prev_q <= line;
                     end
                     default: st_q <= ST_IDLE;
                  endcase
               end
               if (phase_q == PH_LAST) begin
                  votes_q <= '0;
                  case (st_q)
                     ST_START: begin st_q <= ST_DATA; idx_q <= '0; end
                     ST_DATA: begin
                        if (idx_q == nbits - 1'b1) st_q <= par_on ? ST_PAR : ST_STOP;
                        else idx_q <= idx_q + 1'b1;
                     end
                     ST_PAR:  st_q <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   assign rx_char.data = sh_q;
   assign rx_char.fe   = fe_q;
   assign rx_char.pe   = pe_q;

   p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st_q == ST_IDLE && !done));
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/sfr_hold_buf.sv
module sfr_hold_buf
   import sfr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     wr,
   input  rx_char_t wr_char,
   input  logic     rd,
   output rx_char_t q_char,
   output logic     valid,
   output logic     ovr
);

   logic pop;
   assign pop = rd && valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_char <= '0; valid <= 1'b0; ovr <= 1'b0;
      end else if (!en) begin
         q_char <= '0; valid <= 1'b0; ovr <= 1'b0;
      end else if (wr) begin
         if (valid && !pop) begin
            ovr <= 1'b1;
         end else begin
            q_char <= wr_char; valid <= 1'b1; ovr <= 1'b0;
         end
      end else if (pop) begin
         q_char.fe <= 1'b0; q_char.pe <= 1'b0; valid <= 1'b0; ovr <= 1'b0;
      end
   end

   p_pop_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd && valid && !wr) |=> (!valid && !ovr));
   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!valid && !ovr && !q_char.fe && !q_char.pe));
   p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr && valid && !rd) |=> (ovr && valid && $stable(q_char.data)));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
   import sfr_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [2:0]       size_sel,
   input  logic [1:0]       parity_sel,
   input  logic             stop_sel,
   input  logic [DIV_W-1:0] divisor,
   input  logic             irq_en,
   input  logic             rxd,
   input  logic             rd_low,
   output logic [7:0]       data_low,
   output logic             data_hi,
   output logic             frame_err,
   output logic             parity_err,
   output logic             overrun,
   output logic             rx_done,
   output logic             irq
);

   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 8");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W out of range");
      end
   endgenerate

   // the receiver does not use the stop-count setting
   logic unused_stop;
   assign unused_stop = stop_sel;

   logic     tick, line_s, done;
   rx_char_t rx_char, held;
   logic     valid, ovr;

   sfr_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .divisor(divisor), .tick(tick));

   sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s));

   sfr_frame_fsm #(.OVS(OVS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line(line_s),
      .size_sel(size_sel), .parity_sel(parity_sel), .done(done), .rx_char(rx_char));

   sfr_hold_buf u_buf (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .wr(done), .wr_char(rx_char),
      .rd(rd_low), .q_char(held), .valid(valid), .ovr(ovr));

   assign data_low   = held.data[7:0];
   assign data_hi    = held.data[8];
   assign frame_err  = held.fe;
   assign parity_err = held.pe;
   assign overrun    = ovr;
   assign rx_done    = valid;
   assign irq        = valid && irq_en;

   p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && done && !valid) |=> irq);

endmodule

// File: tb/sim_serial_frame_rx.sv
`timescale 1ns/1ps
module sim_serial_frame_rx;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0;
   logic [2:0] size_sel = 3'b011;
   logic [1:0] parity_sel = 2'b00;
   logic stop_sel = 1'b0;
   logic [11:0] divisor = 12'd1;
   logic irq_en = 1'b0;
   logic rxd = 1'b1;
   logic rd_low = 1'b0;
   logic [7:0] data_low;
   logic data_hi, frame_err, parity_err, overrun, rx_done, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   serial_frame_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .size_sel(size_sel),
      .parity_sel(parity_sel), .stop_sel(stop_sel), .divisor(divisor),
      .irq_en(irq_en), .rxd(rxd), .rd_low(rd_low), .data_low(data_low),
      .data_hi(data_hi), .frame_err(frame_err), .parity_err(parity_err),
      .overrun(overrun), .rx_done(rx_done), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int bit_clks();
      return 16 * (int'(divisor) + 1);
   endfunction

   task automatic hold(input logic v, input int clks);
      rxd = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send(input int nb, input int d, input bit badpar, input logic stopv);
      int p = bit_clks();
      logic par;
      hold(1'b0, p);
      par = 1'b0;
      for (int i = 0; i < nb; i++) begin
         hold(d[i], p);
         par ^= d[i];
      end
      if (parity_sel[1]) hold(par ^ parity_sel[0] ^ badpar, p);
      hold(stopv, p);
      rxd = 1'b1;
   endtask

   task automatic pop();
      rd_low = 1'b1;
      @(negedge clk);
      rd_low = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 rx_done", rx_done, 0);
      chk("R1 irq", irq, 0);
      chk("R1 flags", {frame_err, parity_err, overrun}, 0);
   endtask

   task automatic t_byte();
      size_sel = 3'b011; parity_sel = 2'b00;
      send(8, 'hA5, 0, 1'b1);
      chk("R2 8-bit data", data_low, 'hA5);
      chk("R8 rx_done", rx_done, 1);
      chk("R8 irq off", irq, 0);
      irq_en = 1'b1; @(negedge clk);
      chk("R8 irq on", irq, 1);
      pop();
      chk("R9 popped", rx_done, 0);
      chk("R8 irq clears", irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_sizes();
      size_sel = 3'b001;
      send(6, 'hFF, 0, 1'b1);
      chk("R2 6-bit", data_low, 'h3F);
      pop();
      size_sel = 3'b000;
      send(5, 'h15, 0, 1'b1);
      chk("R2 5-bit", data_low, 'h15);
      pop();
      size_sel = 3'b101;
      send(8, 'hC3, 0, 1'b1);
      chk("R2 reserved as 8", data_low, 'hC3);
      pop();
      size_sel = 3'b111;
      send(9, 'h1C3, 0, 1'b1);
      chk("R3 ninth bit", data_hi, 1);
      chk("R3 low bits", data_low, 'hC3);
      pop();
      size_sel = 3'b011;
   endtask

   task automatic t_parity();
      parity_sel = 2'b10;
      send(8, 'h37, 0, 1'b1);
      chk("R4 even ok", parity_err, 0);
      chk("R4 even data", data_low, 'h37);
      pop();
      send(8, 'h37, 1, 1'b1);
      chk("R4 even bad", parity_err, 1);
      pop();
      parity_sel = 2'b11;
      send(8, 'h37, 0, 1'b1);
      chk("R4 odd ok", parity_err, 0);
      pop();
      send(8, 'h37, 1, 1'b1);
      chk("R4 odd bad", parity_err, 1);
      pop();
      chk("R9 flag cleared", parity_err, 0);
      parity_sel = 2'b00;
   endtask

   task automatic t_frame_err();
      send(8, 'h5A, 0, 1'b0);
      chk("R5 frame_err", frame_err, 1);
      chk("R5 data kept", data_low, 'h5A);
      hold(1'b1, bit_clks());
      pop();
      chk("R9 fe cleared", frame_err, 0);
   endtask

   task automatic t_stop_ignored();
      stop_sel = 1'b1;
      send(8, 'h81, 0, 1'b1);
      chk("R6 no fe", frame_err, 0);
      chk("R6 first", data_low, 'h81);
      pop();
      send(8, 'h7E, 0, 1'b1);
      chk("R6 second start", data_low, 'h7E);
      chk("R6 second done", rx_done, 1);
      pop();
      stop_sel = 1'b0;
   endtask

   task automatic t_overrun();
      send(8, 'h11, 0, 1'b1);
      send(8, 'h22, 0, 1'b1);
      chk("R7 overrun", overrun, 1);
      chk("R7 first kept", data_low, 'h11);
      pop();
      chk("R9 overrun cleared", overrun, 0);
      chk("R7 dropped", rx_done, 0);
   endtask

   task automatic t_disable();
      parity_sel = 2'b10;
      send(8, 'h0F, 1, 1'b1);
      chk("R10 pre", parity_err, 1);
      rx_en = 1'b0; @(negedge clk);
      chk("R10 rx_done", rx_done, 0);
      chk("R10 flags", {frame_err, parity_err, overrun}, 0);
      rx_en = 1'b1; parity_sel = 2'b00;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_glitch();
      hold(1'b0, bit_clks() / 4);
      hold(1'b1, 3 * bit_clks());
      chk("R11 glitch", rx_done, 0);
   endtask

   task automatic t_rate();
      divisor = 12'd3;
      repeat (8) @(negedge clk);
      send(8, 'h96, 0, 1'b1);
      chk("R12 divisor 3", data_low, 'h96);
      pop();
      divisor = 12'd1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      t_byte();
      t_sizes();
      t_parity();
      t_frame_err();
      t_stop_ignored();
      t_overrun();
      t_disable();
      t_glitch();
      t_rate();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule